// File: doc/BRIEF.md
# Synchronous Smart-Card Clock and Bit Path

This block drives the bit-level traffic to a smart card working in synchronous mode once the card has been powered and activated. It derives the card clock from the interface clock through a programmable even divider. Under a clock-off control the card clock can be stopped, and while stopped it sits at a selectable idle level. When the clock is released, the first card clock edge is held back by at least half an elementary time unit (ETU).

Card data is captured on the rising card clock edge, with the most significant bit arriving first. Data sent to the card is launched on the falling edge. A direction control chooses transmit or receive. Any change of that control clears the running bit count.

A loadable length counter steps once per card clock period and raises a sticky interrupt when it reaches its all-ones value. Firmware can use this to delimit a reply such as the answer-to-reset, and then reload the counter for the next stretch.

Top module: `sync_card_bitpath`

## Requirements
- R1: After reset the card clock is 0, `io_out` is 1, `io_oe` is 0, and `bit_cnt`, `byte_rdy`, `len_cnt` and `len_irq` are all 0.
- R2: While `clk_off` is 1, `card_clk` equals the `idle_lvl` value from one interface cycle earlier and shows no other edge.
- R3: After `clk_off` goes to 0, the first card clock edge comes exactly (`etu_len`/2) + `div_half` interface cycles after the first interface clock edge that sees `clk_off` low. This is never less than half an ETU.
- R4: While running, `card_clk` toggles every `div_half` interface cycles, so the high and low phases are equal (a `div_half` of 0 acts as 1).
- R5: In receive mode (`dir_tx`=0), `io_in` is captured one interface cycle after each rising card clock edge. It is shifted into `rx_byte` at bit 0, with earlier bits moving toward bit 7, and `bit_cnt` is incremented.
- R6: `byte_rdy` is 1 after every eighth sampled bit and returns to 0 at the next sample.
- R7: In transmit mode (`dir_tx`=1), `io_out` takes `tx_bit` one interface cycle after a falling card clock edge and changes at no other time. `io_oe` follows `dir_tx` one cycle later.
- R8: Any change of `dir_tx` clears `bit_cnt` and `byte_rdy` in the next cycle.
- R9: `len_cnt` increases by one per rising card clock edge and holds at its all-ones value (63 by default).
- R10: `len_irq` sets when `len_cnt` steps into all-ones. It stays set until an `irq_clr` pulse; if a set and a clear fall in the same cycle, the set wins.
- R11: A `len_load` pulse writes `len_value` into `len_cnt`, overriding a coincident count step. Loading all-ones directly raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_off | input | 1 | 1 stops the card clock |
| idle_lvl | input | 1 | Card clock level while stopped |
| div_half | input | DIV_W | Interface cycles per card clock phase |
| etu_len | input | ETU_W | ETU length in interface cycles |
| dir_tx | input | 1 | 1 transmit, 0 receive |
| tx_bit | input | 1 | Next bit to send to the card |
| io_in | input | 1 | IO level from the card |
| len_load | input | 1 | Load pulse for the length counter |
| len_value | input | LEN_W | Value loaded into the length counter |
| irq_clr | input | 1 | Write-one-to-clear of the interrupt |
| card_clk | output | 1 | Clock to the card |
| io_out | output | 1 | IO level driven to the card |
| io_oe | output | 1 | IO output enable |
| bit_cnt | output | CNT_W | Bits moved since the last direction change |
| rx_byte | output | BYTE_W | Receive shift register |
| byte_rdy | output | 1 | Eighth bit of a byte sampled |
| len_cnt | output | LEN_W | Length counter value |
| len_irq | output | 1 | Length counter interrupt |

## Verification
Card clock edges appear one interface cycle after the internal condition that causes them, and the gated level follows `idle_lvl` with one register of delay. Receive capture, `bit_cnt`, `byte_rdy` and `len_cnt` change one cycle after the registered rising edge. `io_out` changes one cycle after the registered falling edge. The bench therefore polls `card_clk` on falling interface edges and, after seeing the card edge it needs, waits one more falling interface edge before sampling the result. Restart delay and phase lengths are checked as exact counts of falling interface edges.

// File: rtl/sccb_pkg.sv
package sccb_pkg;

  typedef enum logic [1:0] {
    CK_GATED = 2'd0,
    CK_WAIT  = 2'd1,
    CK_RUN   = 2'd2
  } ck_state_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } ck_edge_t;

endpackage

// File: rtl/sccb_clkgen.sv
module sccb_clkgen #(
  parameter int DIV_W = 8,
  parameter int ETU_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_off,
  input  logic                 idle_lvl,
  input  logic [DIV_W-1:0]     div_half,
  input  logic [ETU_W-1:0]     etu_len,
  output logic                 card_clk,
  output sccb_pkg::ck_edge_t   edge_o
);
  import sccb_pkg::*;

  localparam logic [ETU_W:0] ONE_E = {{ETU_W{1'b0}}, 1'b1};
  localparam logic [DIV_W:0] ONE_D = {{DIV_W{1'b0}}, 1'b1};

  ck_state_e        state_q, state_d;
  logic [ETU_W-1:0] wait_q, wait_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             clk_q, clk_d;
  ck_edge_t         edge_q, edge_d;

  logic [ETU_W-1:0] half_etu;
  logic [DIV_W-1:0] div_lim;
  logic [ETU_W:0]   wait_nx;
  logic [DIV_W:0]   div_nx;

  assign half_etu = etu_len >> 1;
  assign div_lim  = (div_half == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div_half;
  assign wait_nx  = {1'b0, wait_q} + ONE_E;
  assign div_nx   = {1'b0, div_q} + ONE_D;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    div_d   = div_q;
    clk_d   = clk_q;
    edge_d  = '0;
    if (clk_off) begin
      state_d = CK_GATED;
      clk_d   = idle_lvl;
      wait_d  = '0;
      div_d   = '0;
    end else begin
      case (state_q)
        CK_GATED: begin
          state_d = CK_WAIT;
          wait_d  = '0;
          clk_d   = idle_lvl;
        end
        CK_WAIT: begin
          if (wait_nx >= {1'b0, half_etu}) begin
            state_d = CK_RUN;
            div_d   = '0;
          end else begin
            wait_d = wait_nx[ETU_W-1:0];
          end
        end
        CK_RUN: begin
          if (div_nx >= {1'b0, div_lim}) begin
            div_d       = '0;
            clk_d       = ~clk_q;
            edge_d.rise = ~clk_q;
            edge_d.fall = clk_q;
          end else begin
            div_d = div_nx[DIV_W-1:0];
          end
        end
        default: state_d = CK_GATED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CK_GATED;
      wait_q  <= '0;
      div_q   <= '0;
      clk_q   <= 1'b0;
      edge_q  <= '0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      div_q   <= div_d;
      clk_q   <= clk_d;
      edge_q  <= edge_d;
    end
  end

  assign card_clk = clk_q;
  assign edge_o   = edge_q;

  // R2
  gated_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clk_off)) |-> (card_clk == $past(idle_lvl)));

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CK_WAIT && !clk_off) |=> $stable(clk_q));

  // R4
  edge_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (edge_q.rise || edge_q.fall)) |-> (clk_q != $past(clk_q)));

endmodule

// File: rtl/sccb_bitpath.sv
module sccb_bitpath #(
  parameter int CNT_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  sccb_pkg::ck_edge_t  edge_i,
  input  logic                dir_tx,
  input  logic                tx_bit,
  input  logic                io_in,
  output logic                io_out,
  output logic                io_oe,
  output logic [CNT_W-1:0]    bit_cnt,
  output logic [BYTE_W-1:0]   rx_byte,
  output logic                byte_rdy
);
  localparam int SLOT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(BYTE_W - 1);

  logic              dir_q, dir_d;
  logic              io_q, io_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic              rdy_q, rdy_d;
  logic              toggle;
  logic              slot_end;

  assign toggle   = dir_tx ^ dir_q;
  assign slot_end = (slot_q == LAST_SLOT);

  always_comb begin
    dir_d  = dir_tx;
    io_d   = io_q;
    cnt_d  = cnt_q;
    slot_d = slot_q;
    rx_d   = rx_q;
    rdy_d  = rdy_q;
    if (toggle) begin
      cnt_d  = '0;
      slot_d = '0;
      rdy_d  = 1'b0;
    end else if (!dir_q && edge_i.rise) begin
      rx_d   = {rx_q[BYTE_W-2:0], io_in};
      cnt_d  = cnt_q + 1'b1;
      rdy_d  = slot_end;
      slot_d = slot_end ? '0 : slot_q + 1'b1;
    end else if (dir_q && edge_i.fall) begin
      io_d   = tx_bit;
      cnt_d  = cnt_q + 1'b1;
      rdy_d  = 1'b0;
      slot_d = slot_end ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      io_q   <= 1'b1;
      cnt_q  <= '0;
      slot_q <= '0;
      rx_q   <= '0;
      rdy_q  <= 1'b0;
    end else begin
      dir_q  <= dir_d;
      io_q   <= io_d;
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      rx_q   <= rx_d;
      rdy_q  <= rdy_d;
    end
  end

  assign io_out   = io_q;
  assign io_oe    = dir_q;
  assign bit_cnt  = cnt_q;
  assign rx_byte  = rx_q;
  assign byte_rdy = rdy_q;

  // R7
  io_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(edge_i.fall)) |-> (io_out == $past(io_out)));

  // R8
  dir_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(dir_tx) != $past(dir_q))) |-> (bit_cnt == '0 && !byte_rdy));

  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(edge_i.rise)) |-> (rx_byte == $past(rx_byte)));

endmodule

// File: rtl/sccb_lencnt.sv
module sccb_lencnt #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             len_load,
  input  logic [LEN_W-1:0] len_value,
  input  logic             irq_clr,
  output logic [LEN_W-1:0] len_cnt,
  output logic             len_irq
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [LEN_W-1:0] LEN_PRE = LEN_MAX - 1'b1;

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;

  always_comb begin
    cnt_d = cnt_q;
    irq_d = irq_q;
    if (irq_clr) irq_d = 1'b0;
    if (len_load) begin
      cnt_d = len_value;
    end else if (rise && cnt_q != LEN_MAX) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LEN_PRE) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign len_cnt = cnt_q;
  assign len_irq = irq_q;

  // R9
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rise) && !$past(len_load) && ($past(cnt_q) != LEN_MAX))
      |-> (len_cnt == LEN_W'($past(cnt_q) + 1'b1)));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(irq_q) && !$past(irq_clr)) |-> len_irq);

  // R11
  len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(len_load)) |-> (len_cnt == $past(len_value)));

endmodule

// File: rtl/sync_card_bitpath.sv
module sync_card_bitpath #(
  parameter int DIV_W  = 8,
  parameter int ETU_W  = 12,
  parameter int CNT_W  = 8,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_off,
  input  logic              idle_lvl,
  input  logic [DIV_W-1:0]  div_half,
  input  logic [ETU_W-1:0]  etu_len,
  input  logic              dir_tx,
  input  logic              tx_bit,
  input  logic              io_in,
  input  logic              len_load,
  input  logic [LEN_W-1:0]  len_value,
  input  logic              irq_clr,
  output logic              card_clk,
  output logic              io_out,
  output logic              io_oe,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_rdy,
  output logic [LEN_W-1:0]  len_cnt,
  output logic              len_irq
);
  import sccb_pkg::*;

  ck_edge_t ck_edge;

  sccb_clkgen #(.DIV_W(DIV_W), .ETU_W(ETU_W)) i_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_off  (clk_off),
    .idle_lvl (idle_lvl),
    .div_half (div_half),
    .etu_len  (etu_len),
    .card_clk (card_clk),
    .edge_o   (ck_edge)
  );

  sccb_bitpath #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) i_bitpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_i   (ck_edge),
    .dir_tx   (dir_tx),
    .tx_bit   (tx_bit),
    .io_in    (io_in),
    .io_out   (io_out),
    .io_oe    (io_oe),
    .bit_cnt  (bit_cnt),
    .rx_byte  (rx_byte),
    .byte_rdy (byte_rdy)
  );

  sccb_lencnt #(.LEN_W(LEN_W)) i_lencnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (ck_edge.rise),
    .len_load  (len_load),
    .len_value (len_value),
    .irq_clr   (irq_clr),
    .len_cnt   (len_cnt),
    .len_irq   (len_irq)
  );

endmodule

// File: tb/test_sync_card_bitpath.sv
module test_sync_card_bitpath;
  localparam int CLK_PERIOD = 10;
  localparam int DIVH = 3;
  localparam int ETU  = 16;
  localparam int WATCHDOG = 100000;
  // {stimulus byte, expected rx_byte, expected bit_cnt}
  localparam logic [23:0] VEC [4] = '{
    {8'hA5, 8'hA5, 8'd8}, {8'h3C, 8'h3C, 8'd16},
    {8'hFF, 8'hFF, 8'd24}, {8'h01, 8'h01, 8'd32}};

  logic clk = 1'b0;
  logic rst_n, clk_off, idle_lvl, dir_tx, tx_bit, io_in, len_load, irq_clr;
  logic [7:0]  div_half;
  logic [11:0] etu_len;
  logic [5:0]  len_value;
  logic card_clk, io_out, io_oe, byte_rdy, len_irq;
  logic [7:0] bit_cnt, rx_byte;
  logic [5:0] len_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_card_bitpath i_sync_card_bitpath (
    .clk(clk), .rst_n(rst_n), .clk_off(clk_off), .idle_lvl(idle_lvl),
    .div_half(div_half), .etu_len(etu_len), .dir_tx(dir_tx), .tx_bit(tx_bit),
    .io_in(io_in), .len_load(len_load), .len_value(len_value), .irq_clr(irq_clr),
    .card_clk(card_clk), .io_out(io_out), .io_oe(io_oe), .bit_cnt(bit_cnt),
    .rx_byte(rx_byte), .byte_rdy(byte_rdy), .len_cnt(len_cnt), .len_irq(len_irq));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_level(input logic lvl, output int n);
    n = 0;
    while (card_clk !== lvl && n < 1000) begin
      tick();
      n++;
    end
  endtask

  task automatic rx_bit(input logic b);
    int n;
    io_in = b;
    wait_level(1'b1, n);
    tick();
    wait_level(1'b0, n);
  endtask

  initial begin
    int n;
    int prev;
    rst_n = 1'b0; clk_off = 1'b1; idle_lvl = 1'b0; div_half = 8'(DIVH);
    etu_len = 12'(ETU); dir_tx = 1'b0; tx_bit = 1'b0; io_in = 1'b0;
    len_load = 1'b0; len_value = '0; irq_clr = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 card_clk", card_clk, 0);
    chk("R1 io_out", io_out, 1);
    chk("R1 io_oe", io_oe, 0);
    chk("R1 bit_cnt", bit_cnt, 0);
    chk("R1 byte_rdy", byte_rdy, 0);
    chk("R1 len_cnt", len_cnt, 0);
    chk("R1 len_irq", len_irq, 0);

    // R2 gated clock follows idle level
    idle_lvl = 1'b1;
    tick();
    for (int i = 0; i < 5; i++) begin
      chk("R2 idle high", card_clk, 1);
      tick();
    end
    idle_lvl = 1'b0;
    tick();
    chk("R2 idle low", card_clk, 0);

    // R3 restart delay
    clk_off = 1'b0;
    n = 0;
    while (card_clk !== 1'b1 && n < 1000) begin
      tick();
      n++;
    end
    chk("R3 first edge", n, ETU/2 + DIVH + 1);

    // R4 phase lengths
    wait_level(1'b0, n);
    chk("R4 high phase", n, DIVH);
    wait_level(1'b1, n);
    chk("R4 low phase", n, DIVH);

    // R8 toggles clear the bit counter
    wait_level(1'b0, n);
    dir_tx = 1'b1;
    tick();
    chk("R8 clear on rise of dir", bit_cnt, 0);
    dir_tx = 1'b0;
    tick();
    chk("R8 clear on fall of dir", bit_cnt, 0);

    // R5 R6 receive vectors
    wait_level(1'b0, n);
    for (int v = 0; v < 4; v++) begin
      for (int i = 7; i >= 0; i--) begin
        rx_bit(VEC[v][16 + i]);
        chk("R6 byte_rdy", byte_rdy, (i == 0) ? 1 : 0);
      end
      chk("R5 rx_byte", rx_byte, VEC[v][15:8]);
      chk("R5 bit_cnt", bit_cnt, VEC[v][7:0]);
    end

    // R8 toggle clears byte_rdy; R7 io_oe follows
    dir_tx = 1'b1;
    tick();
    chk("R8 byte_rdy cleared", byte_rdy, 0);
    chk("R8 bit_cnt cleared", bit_cnt, 0);
    chk("R7 io_oe", io_oe, 1);

    // R7 transmit on falling edges only
    tx_bit = 1'b0;
    wait_level(1'b1, n);
    wait_level(1'b0, n);
    tick();
    chk("R7 sync", io_out, 0);
    prev = 0;
    for (int i = 0; i < 4; i++) begin
      tx_bit = i[0] ? 1'b0 : 1'b1;
      wait_level(1'b1, n);
      chk("R7 no change on rise", io_out, prev);
      wait_level(1'b0, n);
      tick();
      chk("R7 update after fall", io_out, tx_bit);
      prev = tx_bit;
    end

    // R11 R9 R10 length counter
    len_value = 6'd60;
    len_load = 1'b1;
    tick();
    len_load = 1'b0;
    chk("R11 load", len_cnt, 60);
    for (int i = 1; i <= 4; i++) begin
      wait_level(1'b1, n);
      tick();
      chk("R9 count", len_cnt, (i < 3) ? 60 + i : 63);
      chk("R10 irq", len_irq, (i < 3) ? 0 : 1);
      wait_level(1'b0, n);
    end
    irq_clr = 1'b1;
    tick();
    irq_clr = 1'b0;
    chk("R10 cleared", len_irq, 0);
    len_value = 6'd63;
    len_load = 1'b1;
    tick();
    len_load = 1'b0;
    tick();
    chk("R11 load max no irq", len_irq, 0);

    // R2 gating mid-run holds idle high, counter stays
    clk_off = 1'b1;
    idle_lvl = 1'b1;
    tick();
    tick();
    len_value = 6'd5;
    len_load = 1'b1;
    tick();
    len_load = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk("R2 stopped high", card_clk, 1);
      tick();
    end
    chk("R9 no count while stopped", len_cnt, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule